// File: doc/BRIEF.md
# FIFO Status Flag Unit

This block produces the five status flags of a dual-clock FIFO: empty, full, half-full, almost-empty and almost-full. The storage, the pointer synchronisers and the data path sit elsewhere. They deliver two occupancy counts, each already valid in its own clock domain. `wr_count` is the write side's view and `rd_count` is the read side's view. Full, half-full and the synchronous almost-full flag are registered on the write clock. Empty and the synchronous almost-empty flag are registered on the read clock.

Two thresholds set the almost flags. One is the empty offset; the other is the full offset. Each is PW bits wide, where the depth is 2^PW. A master reset loads both offsets from one of eight presets. The preset is chosen by a three-bit index, formed from the load input and the two select inputs and sampled on the write clock while master reset is low. After reset, software-side logic can reprogram the offsets in one of two ways. It can write them one at a time from the data bus, or shift them in one bit per write clock.

A mode input gives the almost flags asynchronous timing. In that mode each almost flag is raised by its own side's clock and lowered by the opposite side's clock. A partial reset returns the flags to their reset state but keeps the offsets that were programmed.

Top module: `fifo_flag_unit`

## Requirements
- R1: While master reset or partial reset (both active low, synchronous) is held, the outputs read empty=1, almost_empty=1, full=0, half_full=0 and almost_full=0, whatever the occupancy counts are.
- R2: `empty` is registered on the read clock and is 1 exactly when `rd_count` was 0 at that read clock edge.
- R3: `full` is registered on the write clock and is 1 exactly when `wr_count` equalled the depth 2^PW at that write clock edge.
- R4: `half_full` is registered on the write clock and is 1 exactly when `wr_count` was strictly greater than 2^(PW-1).
- R5: On each write clock edge with master reset low, both offsets are loaded with (8 << k) - 1, where k = {ld, sel[1], sel[0]}. This gives 7, 15, 31, 63, 127, 255, 511 or 1023 for k = 0 to 7.
- R6: With `async_mode`=0, `almost_empty` is registered on the read clock and is 1 when `rd_count` is less than or equal to the empty offset.
- R7: With `async_mode`=0, `almost_full` is registered on the write clock and is 1 when 2^PW - `wr_count` is less than or equal to the full offset.
- R8: With `async_mode`=1, the almost flags behave as follows. `almost_empty` is set on a read clock edge where `rd_count` crosses from above the empty offset to at or below it. It is cleared on a write clock edge where `wr_count` crosses from at or below that offset to above it. `almost_full` is set on a write clock edge where the write-side free space crosses to at or below the full offset. It is cleared on a read clock edge where the read-side free space crosses from at or below that offset to above it.
- R9: Outside reset, each write clock edge with `ld`=1 copies `din` into one offset. The target alternates between the two offsets, starting with the empty offset after any reset.
- R10: Outside reset, with `ld`=0 and `sen`=1, each write clock edge shifts `sdi` in. After 2·PW such edges, the empty offset holds the first PW bits, least significant bit first, and the full offset holds the next PW bits. `ld` takes priority over `sen`. With both low, the offsets hold.
- R11: A partial reset leaves both offsets unchanged, and `ld` and `sen` have no effect while it is held. A later master reset restores the preset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock |
| prst_n | input | 1 | Partial reset, active low, keeps offsets |
| async_mode | input | 1 | 1 selects asynchronous timing for the almost flags |
| sel | input | 2 | Preset index low bits, sampled during master reset |
| ld | input | 1 | Parallel offset load; preset index high bit during master reset |
| sen | input | 1 | Serial offset shift enable |
| sdi | input | 1 | Serial offset data |
| din | input | PW | Parallel offset data |
| wr_count | input | PW+1 | Occupancy as seen in the write domain |
| rd_count | input | PW+1 | Occupancy as seen in the read domain |
| empty | output | 1 | Empty flag (read clock) |
| full | output | 1 | Full flag (write clock) |
| half_full | output | 1 | More than half full (write clock) |
| almost_empty | output | 1 | Almost-empty flag |
| almost_full | output | 1 | Almost-full flag |

## Verification
Each flag settles one rising edge of its own clock after its count changes. In asynchronous mode, a transition appears one edge of whichever clock causes it. A new offset takes effect at the write edge that loads it, so the first flag edge after that load already uses it.

The bench changes inputs only on falling write-clock edges. The two clocks have periods of 20 ns and 26 ns, and their rising edges never coincide. A behavioural model advances on the same rising edges as the design. All five flags are compared against the model on every falling write-clock edge. Each count is held for three write cycles, so that both domains have seen it before the next change.

// File: rtl/fifo_flag_unit.sv
module fifo_flag_unit #(
  parameter int PW = 10
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          async_mode,
  input  logic [1:0]    sel,
  input  logic          ld,
  input  logic          sen,
  input  logic          sdi,
  input  logic [PW-1:0] din,
  input  logic [PW:0]   wr_count,
  input  logic [PW:0]   rd_count,
  output logic          empty,
  output logic          full,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam logic [PW:0] FULL_CNT = {1'b1, {PW{1'b0}}};
  localparam logic [PW:0] HALF_CNT = {2'b01, {(PW-1){1'b0}}};

  logic [PW-1:0] ae_off, af_off, preset_val;
  logic          pl_ptr;
  logic          in_rst;
  logic [2:0]    preset_idx;

  assign in_rst     = !mrst_n || !prst_n;
  assign preset_idx = {ld, sel};

  always_comb
    for (int i = 0; i < PW; i++) preset_val[i] = (i < int'(preset_idx) + 3);

  always_ff @(posedge wclk)
    if (!mrst_n) begin
      ae_off <= preset_val;
      af_off <= preset_val;
      pl_ptr <= 1'b0;
    end else if (!prst_n) begin
      pl_ptr <= 1'b0;
    end else if (ld) begin
      if (pl_ptr) af_off <= din;
      else        ae_off <= din;
      pl_ptr <= ~pl_ptr;
    end else if (sen) begin
      {af_off, ae_off} <= {sdi, af_off, ae_off[PW-1:1]};
    end

  logic [PW:0] free_w, free_r;
  logic        w_le_ae, w_le_af, r_le_ae, r_le_af;
  assign free_w  = FULL_CNT - wr_count;
  assign free_r  = FULL_CNT - rd_count;
  assign w_le_ae = wr_count <= {1'b0, ae_off};
  assign w_le_af = free_w   <= {1'b0, af_off};
  assign r_le_ae = rd_count <= {1'b0, ae_off};
  assign r_le_af = free_r   <= {1'b0, af_off};

  logic ae_q, af_q, ae_w_q, af_r_q;
  logic ae_set_t, ae_clr_t, af_set_t, af_clr_t;
  logic ae_async, af_async;
  assign ae_async = ae_set_t ^ ae_clr_t;
  assign af_async = af_set_t ^ af_clr_t;

  always_ff @(posedge wclk)
    if (in_rst) begin
      full     <= 1'b0;
      half_full<= 1'b0;
      af_q     <= 1'b0;
      ae_w_q   <= 1'b1;
      af_set_t <= 1'b0;
      ae_clr_t <= 1'b0;
    end else begin
      full      <= wr_count == FULL_CNT;
      half_full <= wr_count > HALF_CNT;
      af_q      <= w_le_af;
      ae_w_q    <= w_le_ae;
      if (w_le_af && !af_q && !af_async)   af_set_t <= ~af_set_t;
      if (!w_le_ae && ae_w_q && ae_async)  ae_clr_t <= ~ae_clr_t;
    end

  always_ff @(posedge rclk)
    if (in_rst) begin
      empty    <= 1'b1;
      ae_q     <= 1'b1;
      af_r_q   <= 1'b0;
      ae_set_t <= 1'b1;
      af_clr_t <= 1'b0;
    end else begin
      empty  <= rd_count == '0;
      ae_q   <= r_le_ae;
      af_r_q <= r_le_af;
      if (r_le_ae && !ae_q && !ae_async)   ae_set_t <= ~ae_set_t;
      if (!r_le_af && af_r_q && af_async)  af_clr_t <= ~af_clr_t;
    end

  assign almost_empty = async_mode ? ae_async : ae_q;
  assign almost_full  = async_mode ? af_async : af_q;

  // R9 R10
  offs_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    (!ld && !sen) |=> ($stable(ae_off) && $stable(af_off)));

  // R11
  prst_keep_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_off) && $stable(af_off)));

  // R2
  empty_ae_chk: assert property (@(posedge rclk) disable iff (in_rst)
    empty |-> ae_q);

  // R4
  full_half_chk: assert property (@(posedge wclk) disable iff (in_rst)
    full |-> half_full);

  // R7
  full_af_chk: assert property (@(posedge wclk) disable iff (in_rst)
    full |-> af_q);
endmodule

// File: tb/tb_fifo_flag_unit.sv
module tb_fifo_flag_unit;
  localparam int PW    = 10;
  localparam int DEPTH = 1 << PW;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, async_mode = 0;
  logic [1:0] sel = 0;
  logic ld = 0, sen = 0, sdi = 0;
  logic [PW-1:0] din = 0;
  logic [PW:0] wr_count = 0, rd_count = 0;
  logic empty, full, half_full, almost_empty, almost_full;

  fifo_flag_unit #(.PW(PW)) dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .async_mode(async_mode), .sel(sel), .ld(ld), .sen(sen), .sdi(sdi),
    .din(din), .wr_count(wr_count), .rd_count(rd_count),
    .empty(empty), .full(full), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  int vectors = 0, miscompares = 0;
  bit chk_on = 0, done = 0;
  string tag = "R1";

  // behavioural reference
  int  m_aeo = 7, m_afo = 7;
  bit  m_ptr = 0;
  bit  m_empty = 1, m_full = 0, m_half = 0, m_aes = 1, m_afs = 0;
  bit  m_w_ae_prev = 1, m_r_af_prev = 0;
  time t_ae_set = 1, t_ae_clr = 0, t_af_set = 0, t_af_clr = 0;

  always @(posedge wclk) begin
    int  fr;
    bit  le_ae, le_af;
    if (!mrst_n || !prst_n) begin
      m_full = 0; m_half = 0; m_afs = 0; m_w_ae_prev = 1;
      t_ae_clr = 0; t_af_set = 0;
    end else begin
      fr    = DEPTH - int'(wr_count);
      le_af = fr <= m_afo;
      le_ae = int'(wr_count) <= m_aeo;
      if (le_af && !m_afs) t_af_set = $time;
      if (!le_ae && m_w_ae_prev) t_ae_clr = $time;
      m_full = int'(wr_count) == DEPTH;
      m_half = int'(wr_count) > DEPTH / 2;
      m_afs = le_af;
      m_w_ae_prev = le_ae;
    end
    if (!mrst_n) begin
      m_aeo = (8 << int'({ld, sel})) - 1;
      m_afo = m_aeo;
      m_ptr = 0;
    end else if (!prst_n) begin
      m_ptr = 0;
    end else if (ld) begin
      if (m_ptr) m_afo = int'(din); else m_aeo = int'(din);
      m_ptr = !m_ptr;
    end else if (sen) begin
      m_aeo = (m_aeo >> 1) | ((m_afo & 1) << (PW - 1));
      m_afo = (m_afo >> 1) | (int'(sdi) << (PW - 1));
    end
  end

  always @(posedge rclk) begin
    int fr;
    bit le_ae, le_af;
    if (!mrst_n || !prst_n) begin
      m_empty = 1; m_aes = 1; m_r_af_prev = 0;
      t_ae_set = $time; t_af_clr = $time;
    end else begin
      fr    = DEPTH - int'(rd_count);
      le_af = fr <= m_afo;
      le_ae = int'(rd_count) <= m_aeo;
      if (le_ae && !m_aes) t_ae_set = $time;
      if (!le_af && m_r_af_prev) t_af_clr = $time;
      m_empty = rd_count == 0;
      m_aes = le_ae;
      m_r_af_prev = le_af;
    end
  end

  task automatic chk(string t, string nm, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: got %b expected %b", t, nm, $time, act, exp);
    end
  endtask

  always @(negedge wclk) if (chk_on) begin
    chk(tag, "empty", empty, m_empty);
    chk(tag, "full", full, m_full);
    chk(tag, "half_full", half_full, m_half);
    chk(tag, "almost_empty", almost_empty,
        async_mode ? (t_ae_set > t_ae_clr) : m_aes);
    chk(tag, "almost_full", almost_full,
        async_mode ? (t_af_set > t_af_clr) : m_afs);
  end

  task automatic wc(int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic cnt(int w, int r);
    wr_count = (PW+1)'(w);
    rd_count = (PW+1)'(r);
    wc(3);
  endtask

  task automatic reset_vals(string t);
    chk(t, "empty(reset)", empty, 1'b1);
    chk(t, "almost_empty(reset)", almost_empty, 1'b1);
    chk(t, "full(reset)", full, 1'b0);
    chk(t, "half_full(reset)", half_full, 1'b0);
    chk(t, "almost_full(reset)", almost_full, 1'b0);
  endtask

  task automatic do_mrst(bit am, int idx);
    chk_on = 0;
    mrst_n = 0;
    async_mode = am;
    {ld, sel} = 3'(idx);
    wr_count = (PW+1)'(DEPTH);
    rd_count = (PW+1)'(DEPTH);
    wc(4);
    reset_vals("R1");
    mrst_n = 1; ld = 0; sel = 0;
    wr_count = 0; rd_count = 0;
    wc(3);
    chk_on = 1;
  endtask

  localparam logic [2*PW-1:0] SER = {10'd300, 10'd37};

  initial begin
    do_mrst(0, 0);
    tag = "R2"; cnt(0, 0); cnt(1, 1); cnt(0, 0);
    tag = "R3"; cnt(1024, 1024); cnt(1023, 1023);
    tag = "R4"; cnt(512, 512); cnt(513, 513); cnt(512, 512);
    tag = "R6"; cnt(7, 7); cnt(8, 8); cnt(7, 7);
    tag = "R7"; cnt(1017, 1017); cnt(1016, 1016); cnt(1017, 1017);

    tag = "R5";
    do_mrst(0, 7); cnt(1023, 1023); cnt(1024, 1024); cnt(1, 1); cnt(0, 0);
    do_mrst(0, 3); cnt(63, 63); cnt(64, 64); cnt(961, 961); cnt(960, 960);
    do_mrst(0, 5); cnt(255, 255); cnt(256, 256); cnt(769, 769); cnt(768, 768);

    tag = "R9";
    do_mrst(0, 0);
    ld = 1; din = 100; wc(1); din = 200; wc(1); ld = 0;
    cnt(100, 100); cnt(101, 101); cnt(824, 824); cnt(823, 823);
    ld = 1; din = 50; wc(1); ld = 0;
    cnt(50, 50); cnt(51, 51); cnt(824, 824);

    tag = "R10";
    for (int i = 0; i < 2*PW; i++) begin
      sen = 1; sdi = SER[i]; wc(1);
    end
    sen = 0;
    cnt(37, 37); cnt(38, 38); cnt(724, 724); cnt(723, 723);

    tag = "R11";
    chk_on = 0;
    prst_n = 0; ld = 1; din = 5; sen = 1;
    wr_count = (PW+1)'(DEPTH); rd_count = (PW+1)'(DEPTH);
    wc(4);
    reset_vals("R11");
    prst_n = 1; ld = 0; sen = 0; wr_count = 0; rd_count = 0;
    wc(3); chk_on = 1;
    cnt(37, 37); cnt(38, 38); cnt(724, 724); cnt(723, 723);
    do_mrst(0, 0);
    cnt(7, 7); cnt(8, 8); cnt(1017, 1017); cnt(1016, 1016);

    tag = "R8";
    do_mrst(1, 1);
    cnt(5, 5); cnt(30, 5); cnt(30, 30); cnt(30, 10); cnt(10, 10);
    cnt(1010, 10); cnt(1010, 1010); cnt(1010, 1000); cnt(1000, 1000);
    cnt(15, 1000); cnt(15, 15); cnt(16, 16);

    chk_on = 0;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule